// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the general-purpose register file of a small RISC core that uses register windows for procedure calls. A small bank of global registers is visible from every context. Beside it sits a ring of physical windows. Each window holds three groups of registers: incoming arguments, private locals and outgoing values. The outgoing group of one window is the same storage as the incoming group of the window one level deeper. A callee therefore sees its caller's arguments without any copy.

A call pulse rotates the current window pointer forward and a return pulse rotates it back. A saved-window pointer marks the oldest window still held on chip. If a call finds the ring full, an overflow trap is raised. If a return needs a window that was pushed out to memory, an underflow trap is raised. An external spill/fill sequencer then moves the sixteen private registers of the affected window through a side port and signals completion. The saved pointer then steps by one and the trap clears, after which the core repeats the held call or return.

Top module: `winrf_top`

## Requirements
- R1: Logical registers 0–7 are globals. They map to one storage set that is the same for every window position.
- R2: Logical registers 16–23 are locals, private to the current window. A local written in one window is returned unchanged after a call and a matching return, even if the callee wrote the same logical number.
- R3: Logical registers 24–31 of window w are the same storage as logical registers 8–15 of window w+1 (mod 8). Index i maps to index i.
- R4: An accepted call moves the current pointer to pointer+1 mod 8, and an accepted return moves it to pointer−1 mod 8. The new value is visible one clock after the pulse.
- R5: A call issued when pointer+1 equals the saved pointer leaves the current pointer unchanged and raises the overflow trap one clock later. The overflow and underflow traps are never set together.
- R6: While either trap is pending, call and return pulses have no effect on the pointers or traps.
- R7: During overflow, the transfer read port returns register k of the window at the saved pointer. Here k is 0–7 for incoming registers and 8–15 for locals. A completion pulse advances the saved pointer by one and clears the trap one clock later. The saved pointer never moves while no trap is pending.
- R8: A return issued when the current pointer equals the saved pointer, with at least one window saved in memory, raises the underflow trap and leaves the current pointer unchanged. Transfer writes then fill register k of the window just behind the saved pointer. A completion pulse moves the saved pointer back by one and clears the trap.
- R9: A return at the saved pointer with no windows in memory has no effect. Simultaneous call and return pulses have no effect.
- R10: When a read port addresses the same storage that the write port writes in that cycle, the read returns the new write data.
- R11: After reset both pointers are 0 and both traps are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| call | input | 1 | Procedure call pulse |
| ret | input | 1 | Procedure return pulse |
| rdAddrA | input | 5 | Logical register number, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdAddrB | input | 5 | Logical register number, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Logical register number, write port |
| wrData | input | 32 | Write data |
| xferIdx | input | 4 | Register index within the window being spilled or filled |
| xferWe | input | 1 | Fill write strobe, honoured only during underflow |
| xferWdata | input | 32 | Fill write data |
| xferDone | input | 1 | Sequencer completion pulse |
| xferRdata | output | 32 | Spill read data |
| ovfTrap | output | 1 | Window overflow trap |
| unfTrap | output | 1 | Window underflow trap |
| cwp | output | 3 | Current window pointer |
| swp | output | 3 | Saved window pointer |

## Verification
Read data, including the bypass path and the spill read port, is combinational and is checked a moment after the inputs are driven, in the same cycle. Pointer and trap results are registered and are due one clock after the call, return or completion pulse. The bench drives every pulse on a falling edge and checks the outputs on the next falling edge, after exactly one rising edge. Storage written through the write port or the fill port is read back only on a later cycle.

// File: rtl/winrf_pkg.sv
package winrf_pkg;

  // Strobes passed from the window control to the datapath
  typedef struct packed {
    logic xferWrite;   // fill write into the window behind the saved pointer
    logic xferSelPrev; // transfer port addresses window swp-1 instead of swp
  } winStrobes_t;

endpackage

// File: rtl/winrf_ctrl.sv
module winrf_ctrl
  import winrf_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CNT_W = 8,
  localparam int PW   = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          call,
  input  logic          ret,
  input  logic          xferWe,
  input  logic          xferDone,
  output logic [PW-1:0] cwp,
  output logic [PW-1:0] swp,
  output logic          ovfTrap,
  output logic          unfTrap,
  output winStrobes_t   strb
);

  logic [CNT_W-1:0] savedCnt;
  logic [PW-1:0]    cwpNext, cwpPrev, swpNext, swpPrev;
  logic             trapPend, callOk, retOk;

  always_comb begin
    cwpNext  = (cwp == PW'(NWIN-1)) ? '0 : cwp + PW'(1);
    cwpPrev  = (cwp == '0) ? PW'(NWIN-1) : cwp - PW'(1);
    swpNext  = (swp == PW'(NWIN-1)) ? '0 : swp + PW'(1);
    swpPrev  = (swp == '0) ? PW'(NWIN-1) : swp - PW'(1);
    trapPend = ovfTrap | unfTrap;
    callOk   = call & ~ret & ~trapPend;
    retOk    = ret & ~call & ~trapPend;
    strb.xferSelPrev = unfTrap;
    strb.xferWrite   = unfTrap & xferWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwp      <= '0;
      swp      <= '0;
      savedCnt <= '0;
      ovfTrap  <= 1'b0;
      unfTrap  <= 1'b0;
    end else begin
      if (callOk) begin
        if (cwpNext == swp) ovfTrap <= 1'b1;
        else                cwp     <= cwpNext;
      end
      if (retOk) begin
        if (cwp != swp)          cwp     <= cwpPrev;
        else if (savedCnt != '0) unfTrap <= 1'b1;
      end
      if (xferDone && ovfTrap) begin
        swp     <= swpNext;
        ovfTrap <= 1'b0;
        if (savedCnt != '1) savedCnt <= savedCnt + CNT_W'(1);
      end else if (xferDone && unfTrap) begin
        swp      <= swpPrev;
        unfTrap  <= 1'b0;
        savedCnt <= savedCnt - CNT_W'(1);
      end
    end
  end

  AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfTrap && unfTrap)); // R5
  AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfTrap) |-> (cwpNext == swp)); // R5
  AST_TRAP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (ovfTrap || unfTrap) |=> $stable(cwp)); // R6
  AST_SWP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfTrap || unfTrap) |=> $stable(swp)); // R7
  AST_UNF_AT_ROOT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unfTrap) |-> (cwp == swp && savedCnt != '0)); // R8
  AST_ROOT_RET: assert property (@(posedge clk) disable iff (!rstN)
    (ret && !call && !ovfTrap && !unfTrap && cwp == swp && savedCnt == '0)
      |=> ($stable(cwp) && !unfTrap)); // R9

endmodule

// File: rtl/winrf_dp.sv
module winrf_dp
  import winrf_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int AREA  = 8,
  parameter int DW    = 32,
  localparam int PW    = $clog2(NWIN),
  localparam int AW    = $clog2(AREA),
  localparam int LAW   = AW + 2,
  localparam int IW    = AW + 1,
  localparam int WINSZ = 2 * AREA,
  localparam int NPHYS = NWIN * WINSZ + AREA,
  localparam int PHW   = $clog2(NPHYS)
) (
  input  logic           clk,
  input  logic [PW-1:0]  cwp,
  input  logic [PW-1:0]  swp,
  input  winStrobes_t    strb,
  input  logic [LAW-1:0] rdAddrA,
  output logic [DW-1:0]  rdDataA,
  input  logic [LAW-1:0] rdAddrB,
  output logic [DW-1:0]  rdDataB,
  input  logic           wrEn,
  input  logic [LAW-1:0] wrAddr,
  input  logic [DW-1:0]  wrData,
  input  logic [IW-1:0]  xferIdx,
  input  logic [DW-1:0]  xferWdata,
  output logic [DW-1:0]  xferRdata
);

  logic [DW-1:0] rf [NPHYS];
  logic [PHW-1:0] physA, physB, physW, physX;
  logic [PW-1:0]  xferWin;

  function automatic logic [PHW-1:0] mapReg(input logic [LAW-1:0] a,
                                            input logic [PW-1:0] w);
    int idx, win, r;
    idx = int'(a[AW-1:0]);
    win = int'(w);
    case (a[LAW-1:AW])
      2'd0:    r = NWIN * WINSZ + idx;                  // globals
      2'd1:    r = win * WINSZ + idx;                   // incoming
      2'd2:    r = win * WINSZ + AREA + idx;            // locals
      default: r = ((win + 1) % NWIN) * WINSZ + idx;    // outgoing = next incoming
    endcase
    return PHW'(r);
  endfunction

  always_comb begin
    physA   = mapReg(rdAddrA, cwp);
    physB   = mapReg(rdAddrB, cwp);
    physW   = mapReg(wrAddr, cwp);
    xferWin = strb.xferSelPrev ? ((swp == '0) ? PW'(NWIN-1) : swp - PW'(1)) : swp;
    physX   = PHW'(int'(xferWin) * WINSZ + int'(xferIdx));
    rdDataA = (wrEn && physW == physA) ? wrData : rf[physA];
    rdDataB = (wrEn && physW == physB) ? wrData : rf[physB];
    xferRdata = rf[physX];
  end

  always_ff @(posedge clk) begin
    if (wrEn)           rf[physW] <= wrData;
    if (strb.xferWrite) rf[physX] <= xferWdata;
  end

  AST_BYPASS_A: assert property (@(posedge clk)
    (wrEn && wrAddr == rdAddrA) |-> (rdDataA == wrData)); // R10
  AST_BYPASS_B: assert property (@(posedge clk)
    (wrEn && wrAddr == rdAddrB) |-> (rdDataB == wrData)); // R10

endmodule

// File: rtl/winrf_top.sv
module winrf_top
  import winrf_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int AREA  = 8,
  parameter int DW    = 32,
  parameter int CNT_W = 8,
  localparam int PW   = $clog2(NWIN),
  localparam int AW   = $clog2(AREA),
  localparam int LAW  = AW + 2,
  localparam int IW   = AW + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           call,
  input  logic           ret,
  input  logic [LAW-1:0] rdAddrA,
  output logic [DW-1:0]  rdDataA,
  input  logic [LAW-1:0] rdAddrB,
  output logic [DW-1:0]  rdDataB,
  input  logic           wrEn,
  input  logic [LAW-1:0] wrAddr,
  input  logic [DW-1:0]  wrData,
  input  logic [IW-1:0]  xferIdx,
  input  logic           xferWe,
  input  logic [DW-1:0]  xferWdata,
  input  logic           xferDone,
  output logic [DW-1:0]  xferRdata,
  output logic           ovfTrap,
  output logic           unfTrap,
  output logic [PW-1:0]  cwp,
  output logic [PW-1:0]  swp
);

  winStrobes_t strb;

  winrf_ctrl #(.NWIN(NWIN), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .call(call), .ret(ret),
    .xferWe(xferWe), .xferDone(xferDone),
    .cwp(cwp), .swp(swp), .ovfTrap(ovfTrap), .unfTrap(unfTrap), .strb(strb)
  );

  winrf_dp #(.NWIN(NWIN), .AREA(AREA), .DW(DW)) uDp (
    .clk(clk), .cwp(cwp), .swp(swp), .strb(strb),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .xferIdx(xferIdx), .xferWdata(xferWdata), .xferRdata(xferRdata)
  );

endmodule

// File: tb/sim_winrf_top.sv
`timescale 1ns/1ps
module sim_winrf_top;

  logic        clk = 1'b0;
  logic        rstN, call, ret, wrEn, xferWe, xferDone;
  logic [4:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData, xferWdata, xferRdata;
  logic [3:0]  xferIdx;
  logic        ovfTrap, unfTrap;
  logic [2:0]  cwp, swp;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  winrf_top u0 (
    .clk(clk), .rstN(rstN), .call(call), .ret(ret),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .xferIdx(xferIdx), .xferWe(xferWe), .xferWdata(xferWdata),
    .xferDone(xferDone), .xferRdata(xferRdata),
    .ovfTrap(ovfTrap), .unfTrap(unfTrap), .cwp(cwp), .swp(swp)
  );

  // {call, ret, expected cwp[2:0], expected overflow}
  localparam logic [5:0] VEC [11] = '{
    6'b11_000_0,  // both pulses: no effect (R9)
    6'b01_000_0,  // return at root, nothing saved (R9)
    6'b10_001_0, 6'b10_010_0, 6'b10_011_0, 6'b10_100_0,
    6'b10_101_0, 6'b10_110_0, 6'b10_111_0,  // calls advance (R4)
    6'b10_111_1,  // ring full: overflow, pointer held (R5)
    6'b01_111_1   // return ignored while trap pending (R6)
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic c, input logic r);
    @(negedge clk); call = c; ret = r;
    @(negedge clk); call = 1'b0; ret = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdA(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk); rdAddrA = a; #1;
    chk(req, rdDataA, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; call = 0; ret = 0; wrEn = 0; xferWe = 0; xferDone = 0;
    rdAddrA = 0; rdAddrB = 0; wrAddr = 0; wrData = 0; xferWdata = 0; xferIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R11 cwp", 32'(cwp), 0);
    chk("R11 swp", 32'(swp), 0);
    chk("R11 ovf", 32'(ovfTrap), 0);
    chk("R11 unf", 32'(unfTrap), 0);

    // window 0: global, local, outgoing; bypass on the local write
    wr(5'd5, 32'h11);
    @(negedge clk); wrEn = 1'b1; wrAddr = 5'd17; wrData = 32'h22;
    rdAddrA = 5'd17; rdAddrB = 5'd17; #1;
    chk("R10 bypass A", rdDataA, 32'h22);
    chk("R10 bypass B", rdDataB, 32'h22);
    @(negedge clk); wrEn = 1'b0;
    wr(5'd25, 32'h33);

    op(1, 0);
    chk("R4 call", 32'(cwp), 1);
    rdA("R1 global", 5'd5, 32'h11);
    rdA("R3 alias", 5'd9, 32'h33);
    wr(5'd17, 32'h44);
    rdA("R2 callee local", 5'd17, 32'h44);
    op(0, 1);
    chk("R4 return", 32'(cwp), 0);
    rdA("R2 caller local", 5'd17, 32'h22);

    foreach (VEC[i]) begin
      op(VEC[i][5], VEC[i][4]);
      chk("R4/R5/R6/R9 table cwp", 32'(cwp), 32'(VEC[i][3:1]));
      chk("R5/R6 table ovf", 32'(ovfTrap), 32'(VEC[i][0]));
    end

    // spill window 0 (R7)
    @(negedge clk); xferIdx = 4'd9; #1;
    chk("R7 spill read", xferRdata, 32'h22);
    @(negedge clk); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    chk("R7 swp step", 32'(swp), 1);
    chk("R7 ovf clear", 32'(ovfTrap), 0);
    op(1, 0);
    chk("R4 wrap", 32'(cwp), 0);

    for (int k = 0; k < 7; k++) op(0, 1);
    chk("R4 return chain", 32'(cwp), 1);
    chk("R8 no early unf", 32'(unfTrap), 0);
    op(0, 1);
    chk("R8 unf raised", 32'(unfTrap), 1);
    chk("R8 cwp held", 32'(cwp), 1);

    // fill window 0 (R8)
    @(negedge clk); xferIdx = 4'd9; xferWe = 1'b1; xferWdata = 32'h55;
    @(negedge clk); xferWe = 1'b0;
    @(negedge clk); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    chk("R8 swp back", 32'(swp), 0);
    chk("R8 unf clear", 32'(unfTrap), 0);
    op(0, 1);
    chk("R8 return after fill", 32'(cwp), 0);
    rdA("R8 filled local", 5'd17, 32'h55);
    op(0, 1);
    chk("R9 root cwp", 32'(cwp), 0);
    chk("R9 root unf", 32'(unfTrap), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule